// File: doc/BRIEF.md
# Fused Digit-Serial Multiply-Accumulate over GF(2^83)

This unit computes R = A·(B ⊕ D) ⊕ C reduced modulo P. A, B, C and D are polynomials over GF(2) of degree below 83. P = x^83 + p(x), where the 83-bit input `poly` carries the low coefficients p(x). Bit i of every operand word is the coefficient of x^i. Sum means XOR, so B ⊕ D is formed before the multiply, and C is folded into the reduced product at the end.

The multiplier (B ⊕ D) is taken 12 bits per clock, starting with the most significant digit. Each digit step shifts the accumulator up by 12 positions, adds the digit-weighted copies of A, and then clears the 12 overflow positions one bit at a time from the top down. The operation therefore takes ceil(83/12) = 7 step cycles for any operand values. `poly` can change from one operation to the next, so any degree-83 reduction polynomial can be used.

A host presents the operands and the polynomial, pulses `start` for one cycle, and reads `result` when `done` pulses.

Top module: `gf_fused_malu`

## Requirements
- R1: After an operation, `result` equals A·(B ⊕ D) ⊕ C mod (x^83 + poly), with all 83 bits reduced. If A = 0 or B = D, this gives C. If every operand is zero, it gives zero.
- R2: The polynomial is taken from `poly` at each start. Two different polynomials give results reduced by their own polynomial. For example, x·x^82 gives `poly` itself.
- R3: Latency is fixed. If `start` is sampled high at rising edge e0, then `done` is high in the cycle that follows rising edge e0+7, whatever the operand values.
- R4: `done` is high for exactly one clock cycle per operation.
- R5: `busy` is high from the edge that samples `start` until the edge that raises `done`. A `start` pulse seen while `busy` is high is ignored: it neither restarts nor adds an operation, and no extra `done` follows.
- R6: Operands and `poly` are captured on the start edge. Changing the inputs later has no effect on the result.
- R7: `result` holds its value in every cycle except the one in which `done` is high.
- R8: While `rst_n` is low, and at the end of reset, `busy`, `done` and `result` are all zero. This holds even if an operation was in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, sampled while idle |
| op_a | input | 83 | Multiplicand A |
| op_b | input | 83 | Addend B of the multiplier |
| op_d | input | 83 | Addend D of the multiplier |
| op_c | input | 83 | Accumulate term C |
| poly | input | 83 | Low coefficients of P (the x^83 term is implicit) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when `result` is new |
| result | output | 83 | Reduced result |

## Verification
A hand-worked table covers several patterns:
- Unit multiplicands, with and without a carry past x^82.
- A zero multiplicand, and B equal to D, both of which must give C.
- All-zero operands.
- A case where C cancels the reduced product.

The x·x^82 case under two different polynomials can only pass if reduction uses the runtime `poly` and the implicit top term. Random operands under both polynomials are compared with a bit-serial Horner model. Such operands drive every digit and every overflow bit, so they expose errors in digit order or reduction order that the sparse table cannot. Separate sequences cover reset mid-operation, start pulses and input changes while busy, the latency count, and the one-cycle `done` pulse.

// File: rtl/malu_pkg.sv
package malu_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } ctl_state_t;

   function automatic int unsigned digits_for(input int unsigned width, input int unsigned dig);
      return (width + dig - 1) / dig;
   endfunction

endpackage

// File: rtl/gf_red_slice.sv
// One reduction slice: clears bit POS by folding in (x^K + poly) aligned to POS.
module gf_red_slice #(
   parameter int unsigned K   = 83,
   parameter int unsigned W   = 95,
   parameter int unsigned POS = 94
) (
   input  logic [W-1:0] w_in,
   input  logic [K-1:0] poly,
   output logic [W-1:0] w_out
);
   localparam int unsigned SH = POS - K;

   if (POS < K || POS >= W) begin : g_bad_pos
      $error("gf_red_slice: POS out of range");
   end

   logic [W-1:0] fold;

   always_comb begin
      fold  = W'({1'b1, poly}) << SH;
      w_out = w_in ^ ({W{w_in[POS]}} & fold);
   end

endmodule

// File: rtl/gf_digit_step.sv
// Combinational digit step: acc*x^D + A*digit, then reduced back below x^K.
module gf_digit_step #(
   parameter int unsigned K = 83,
   parameter int unsigned D = 12
) (
   input  logic [K-1:0] acc,
   input  logic [K-1:0] mcand,
   input  logic [D-1:0] digit,
   input  logic [K-1:0] poly,
   output logic [K-1:0] acc_next
);
   localparam int unsigned W = K + D;

   logic [D:0][W-1:0] pp;
   logic [D:0][W-1:0] red;

   assign pp[0] = {acc, {D{1'b0}}};

   for (genvar i = 0; i < D; i++) begin : g_pp
      assign pp[i+1] = pp[i] ^ ({W{digit[i]}} & (W'(mcand) << i));
   end

   assign red[0] = pp[D];

   for (genvar j = 0; j < D; j++) begin : g_red
      gf_red_slice #(
         .K  (K),
         .W  (W),
         .POS(W - 1 - j)
      ) u_slice (
         .w_in (red[j]),
         .poly (poly),
         .w_out(red[j+1])
      );
   end

   assign acc_next = red[D][K-1:0];

   // R1
   always_comb begin
      red_clear_chk : assert (red[D][W-1:K] == '0)
         else $error("reduction chain left overflow bits set");
   end

endmodule

// File: rtl/gf_seq_ctrl.sv
// Sequencer: fixed count of NDIG step cycles per accepted start.
module gf_seq_ctrl
   import malu_pkg::*;
#(
   parameter int unsigned NDIG = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic load,
   output logic last,
   output logic done
);
   localparam int unsigned CW = (NDIG > 1) ? $clog2(NDIG) : 1;

   if (NDIG < 1) begin : g_bad_ndig
      $error("gf_seq_ctrl: NDIG must be at least 1");
   end

   ctl_state_t     state;
   logic [CW-1:0]  cnt;

   assign busy = (state == ST_RUN);
   assign load = start && (state == ST_IDLE);
   assign last = busy && (cnt == CW'(NDIG - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= last;
         if (load) begin
            state <= ST_RUN;
            cnt   <= '0;
         end else if (busy) begin
            if (last) begin
               state <= ST_IDLE;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R4
   done_pulse_chk : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done held longer than one cycle");

   // R3
   done_after_run_chk : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)))
      else $error("done not at end of run");

   // R5
   restart_ignored_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !last) |=> (busy && cnt == $past(cnt) + 1'b1))
      else $error("start during run disturbed the sequence");

   // R3
   cnt_range_chk : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt < CW'(NDIG)))
      else $error("step counter out of range");

endmodule

// File: rtl/gf_fused_malu.sv
// Digit-serial A*(B^D)^C mod (x^K + poly) over GF(2).
module gf_fused_malu
   import malu_pkg::*;
#(
   parameter int unsigned K = 83,
   parameter int unsigned D = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [K-1:0] op_a,
   input  logic [K-1:0] op_b,
   input  logic [K-1:0] op_d,
   input  logic [K-1:0] op_c,
   input  logic [K-1:0] poly,
   output logic         busy,
   output logic         done,
   output logic [K-1:0] result
);
   localparam int unsigned NDIG = digits_for(K, D);
   localparam int unsigned MW   = NDIG * D;
   localparam int unsigned LW   = $clog2(NDIG + 2);

   if (K < 2) begin : g_bad_k
      $error("gf_fused_malu: K must be at least 2");
   end
   if (D < 1 || D > K) begin : g_bad_d
      $error("gf_fused_malu: D must lie in 1..K");
   end

   logic          load, last;
   logic [K-1:0]  a_q, c_q, p_q, acc_q, step_out;
   logic [MW-1:0] m_q;

   gf_seq_ctrl #(.NDIG(NDIG)) u_ctrl (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .busy (busy),
      .load (load),
      .last (last),
      .done (done)
   );

   gf_digit_step #(.K(K), .D(D)) u_step (
      .acc     (acc_q),
      .mcand   (a_q),
      .digit   (m_q[MW-1 -: D]),
      .poly    (p_q),
      .acc_next(step_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= '0;
         c_q    <= '0;
         p_q    <= '0;
         m_q    <= '0;
         acc_q  <= '0;
         result <= '0;
      end else if (load) begin
         a_q   <= op_a;
         c_q   <= op_c;
         p_q   <= poly;
         m_q   <= MW'(op_b ^ op_d);
         acc_q <= '0;
      end else if (busy) begin
         acc_q <= step_out;
         m_q   <= m_q << D;
         if (last) begin
            result <= step_out ^ c_q;
         end
      end
   end

   // Checker state: cycles since the accepted start.
   logic [LW-1:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lat_q <= '0;
      else if (load)    lat_q <= '0;
      else if (busy)    lat_q <= lat_q + 1'b1;
   end

   // R3
   fixed_latency_chk : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q == LW'(NDIG)))
      else $error("done latency differs from digit count");

   // R7
   result_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result))
      else $error("result changed without done");

   // R6
   operand_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(a_q) && $stable(c_q) && $stable(p_q)))
      else $error("captured operands changed during run");

   // R5
   busy_start_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy)
      else $error("idle start did not begin a run");

endmodule

// File: tb/sim_gf_fused_malu.sv
module sim_gf_fused_malu;
   localparam int K = 83;
   localparam int D = 12;
   localparam int LAT_NEG = 8;  // negedges from the start-driving negedge to done

   localparam logic [K-1:0] POLY0 = 83'h95;    // x^7+x^4+x^2+1
   localparam logic [K-1:0] POLY1 = 83'h2101;  // x^13+x^8+1
   localparam logic [K-1:0] TOP   = 83'd1 << 82;
   localparam logic [K-1:0] X81   = 83'd1 << 81;
   localparam logic [K-1:0] K1    = 83'h5_A5A5_0F0F_3C3C_9999_1234;
   localparam logic [K-1:0] K2    = 83'h3_0001_FFFF_8000_2468_ACE1;

   typedef struct packed {
      logic [K-1:0] a, b, d, c, e;
      logic         ps;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{a: 83'd1, b: TOP,  d: 83'd0, c: 83'd0, e: TOP,    ps: 1'b0},
      '{a: 83'd2, b: TOP,  d: 83'd0, c: 83'd0, e: POLY0,  ps: 1'b0},
      '{a: 83'd2, b: TOP,  d: 83'd0, c: 83'd0, e: POLY1,  ps: 1'b1},
      '{a: 83'd0, b: K1,   d: K2,    c: K2,    e: K2,     ps: 1'b0},
      '{a: K1,    b: K2,   d: K2,    c: K1,    e: K1,     ps: 1'b1},
      '{a: 83'd1, b: 83'd5,d: 83'd1, c: 83'd3, e: 83'd7,  ps: 1'b0},
      '{a: 83'd4, b: X81,  d: 83'd0, c: POLY0, e: 83'd0,  ps: 1'b0},
      '{a: 83'd0, b: 83'd0,d: 83'd0, c: 83'd0, e: 83'd0,  ps: 1'b1}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [K-1:0] op_a = '0, op_b = '0, op_d = '0, op_c = '0, poly = '0;
   logic         busy, done;
   logic [K-1:0] result;

   int n_run  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   gf_fused_malu #(.K(K), .D(D)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .op_a(op_a), .op_b(op_b), .op_d(op_d), .op_c(op_c), .poly(poly),
      .busy(busy), .done(done), .result(result)
   );

   function automatic logic [K-1:0] ref_model(input logic [K-1:0] a, b, d, c, p);
      logic [K-1:0] m = b ^ d;
      logic [K:0]   r = '0;
      for (int i = K - 1; i >= 0; i--) begin
         r = r << 1;
         if (r[K]) r = r ^ {1'b1, p};
         if (m[i]) r[K-1:0] = r[K-1:0] ^ a;
      end
      return r[K-1:0] ^ c;
   endfunction

   function automatic logic [K-1:0] rnd_word();
      logic [95:0] t = {$urandom(), $urandom(), $urandom()};
      return t[K-1:0];
   endfunction

   task automatic chk(input string req, input logic [K-1:0] act, input logic [K-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [K-1:0] a, b, d, c, p,
                         output logic [K-1:0] res, output int lat);
      @(negedge clk);
      op_a = a; op_b = b; op_d = d; op_c = c; poly = p;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      res = result;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL R3 watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [K-1:0] res, exp, held, ra, rb, rd, rc;
      int lat, extra;

      // R8: reset state
      repeat (3) @(negedge clk);
      chk("R8 busy in reset", K'(busy), '0);
      chk("R8 done in reset", K'(done), '0);
      chk("R8 result in reset", result, '0);
      rst_n = 1'b1;

      // R1 R2 R3 R4 R7: directed vector table
      for (int v = 0; v < NV; v++) begin
         run_op(VECS[v].a, VECS[v].b, VECS[v].d, VECS[v].c,
                VECS[v].ps ? POLY1 : POLY0, res, lat);
         chk(VECS[v].ps ? "R2 table result" : "R1 table result", res, VECS[v].e);
         chk("R3 table latency", K'(lat), K'(LAT_NEG));
         @(negedge clk);
         chk("R4 done one cycle", K'(done), '0);
         held = result;
         repeat (3) @(negedge clk);
         chk("R7 result held", result, held);
      end

      // R1 R2 R3: random operands under both polynomials
      for (int ps = 0; ps < 2; ps++) begin
         for (int n = 0; n < 40; n++) begin
            ra = rnd_word(); rb = rnd_word(); rd = rnd_word(); rc = rnd_word();
            exp = ref_model(ra, rb, rd, rc, ps ? POLY1 : POLY0);
            run_op(ra, rb, rd, rc, ps ? POLY1 : POLY0, res, lat);
            chk(ps ? "R2 random result" : "R1 random result", res, exp);
            chk("R3 random latency", K'(lat), K'(LAT_NEG));
         end
      end

      // R5 R6: restart and input changes while busy are ignored
      ra = rnd_word(); rb = rnd_word(); rd = rnd_word(); rc = rnd_word();
      exp = ref_model(ra, rb, rd, rc, POLY0);
      @(negedge clk);
      op_a = ra; op_b = rb; op_d = rd; op_c = rc; poly = POLY0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      op_a = rnd_word(); op_b = rnd_word(); op_d = rnd_word(); op_c = rnd_word(); poly = POLY1;
      lat = 1;
      chk("R5 busy after start", K'(busy), 83'd1);
      @(negedge clk); lat++;
      @(negedge clk); lat++;
      start = 1'b1;
      @(negedge clk); lat++;
      start = 1'b0;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      chk("R6 inputs after start ignored", result, exp);
      chk("R5 restart kept latency", K'(lat), K'(LAT_NEG));
      extra = 0;
      repeat (12) begin
         @(negedge clk);
         if (done) extra++;
      end
      chk("R5 no extra done", K'(extra), '0);
      chk("R5 idle after run", K'(busy), '0);

      // R8: reset in flight
      @(negedge clk);
      op_a = rnd_word(); op_b = rnd_word(); op_d = 83'd0; op_c = rnd_word(); poly = POLY0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8 busy after reset", K'(busy), '0);
      chk("R8 done after reset", K'(done), '0);
      chk("R8 result after reset", result, '0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk("R8 no done after aborted run", K'(done), '0);

      finish_run();
   end

endmodule